// File: doc/BRIEF.md
# Parallel Flash Command and Erase Engine

This block models the control side of a small byte-wide NOR-style flash memory. A host drives chip enable, output enable, write enable, an address and a data byte, all active-low strobes, sampled by the system clock. Qualified write cycles feed a command decoder. It recognises a four-cycle byte program sequence and a six-cycle erase sequence, whose last cycle selects one sector, one block of sixteen sectors or the whole array. The unlock addresses and command bytes are parameters.

An accepted command starts a timed busy phase. During this phase a program performs a read-modify-write on one byte, and an erase walks its address range writing 0xFF, one byte per clock. While the block is busy, reads return status instead of array data, and every write is ignored. The array model is a dual-port memory that block RAM can hold. Erased bytes read as 0xFF.

Top module: `pflash_engine`

## Requirements
- R1: After reset, a read drives the addressed array byte onto `dout`, and a byte never programmed reads 0xFF.
- R2: A program is four qualified writes: `UNLOCK_A`/`K_UNL1`, `UNLOCK_B`/`K_UNL2`, `UNLOCK_A`/`K_PROG`, then the target address and data. The stored byte becomes the old byte ANDed with the new data.
- R3: While a program is busy, `dout[7]` is the complement of bit 7 of the programmed data. `dout[6]` inverts at the start of every read (chip enable and output enable both low after not being so). When the program completes, two successive reads return the same true data.
- R4: Unlock, unlock, `K_ERS` at `UNLOCK_A`, unlock, unlock, then `K_SECT` at any address erases only the `SECTOR_BYTES` sector holding that address to 0xFF. While the erase runs, `dout[7]` reads 0.
- R5: The same five-cycle prefix followed by `K_BLK` erases only the block of `BLOCK_SECTORS` adjacent sectors holding the address.
- R6: The same prefix followed by `K_CHIP` at `UNLOCK_A` erases the whole array, whatever its contents. After only the first five erase cycles, reads still return unchanged array data.
- R7: While a program or erase is busy, every write cycle is ignored, and the command decoder is held in its idle state.
- R8: A write cycle that does not match the next expected step returns the decoder to idle. That cycle does not count as a first unlock cycle.
- R9: A write cycle is inhibited while output enable is low, chip enable is high or write enable is high.
- R10: A write strobe (chip enable and write enable low, output enable high) held for fewer than `MIN_PULSE` clock cycles is ignored.
- R11: While `supply_low` is high, no write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| supply_low | input | 1 | Supply-low indication; blocks all writes when high |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, or status while busy |

## Verification
The assertions check, on every cycle, the following properties:
- a low output enable or a high `supply_low` never lets a write through;
- the decoder issues no operation while busy;
- the toggle bit holds its value outside the busy phase;
- an erase walk advances one byte per clock.

Only the bench scenarios can show the rest:
- the array contents after each command;
- the complement-of-data and zero polling values;
- that erases stay within their sector or block;
- that broken, short or busy-time sequences leave the array unchanged.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_e;
endpackage

// File: rtl/pflash_wfilt.sv
// Qualifies host write strobes: inhibit states, supply sense, minimum width.
module pflash_wfilt #(
  parameter int AW        = 9,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          supply_low,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [CW-1:0] cnt;
  logic          strobe;
  logic          end_ok;

  assign strobe = ~ce_n & ~we_n & oe_n & ~supply_low;
  // a strobe only completes cleanly when released by CE#/WE# with OE# high
  assign end_ok = (ce_n | we_n) & oe_n & ~supply_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (strobe) begin
        if (cnt != CW'(MIN_PULSE)) cnt <= cnt + 1'b1;
        wr_addr <= addr;
        wr_data <= din;
      end else begin
        wr_valid <= end_ok && (cnt == CW'(MIN_PULSE));
        cnt      <= '0;
      end
    end
  end

  // R11
  supply_cut_chk: assert property (@(posedge clk) disable iff (rst)
    supply_low |=> !wr_valid);
  // R9
  oe_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> !wr_valid);
endmodule

// File: rtl/pflash_cmdseq.sv
// Unlock and command sequence decoder.
module pflash_cmdseq
  import pflash_pkg::*;
#(
  parameter int         AW       = 9,
  parameter int         UNLOCK_A = 'h055,
  parameter int         UNLOCK_B = 'h0AA,
  parameter logic [7:0] K_UNL1   = 8'hAA,
  parameter logic [7:0] K_UNL2   = 8'h55,
  parameter logic [7:0] K_PROG   = 8'hA0,
  parameter logic [7:0] K_ERS    = 8'h80,
  parameter logic [7:0] K_CHIP   = 8'h10,
  parameter logic [7:0] K_SECT   = 8'h30,
  parameter logic [7:0] K_BLK    = 8'h50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic          op_valid,
  output op_e           op_kind,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data
);
  typedef enum logic [2:0] {
    D_IDLE, D_U1, D_U2, D_PGM, D_E1, D_E2, D_E3
  } dstate_e;

  localparam logic [AW-1:0] ADR_A = AW'(UNLOCK_A);
  localparam logic [AW-1:0] ADR_B = AW'(UNLOCK_B);

  dstate_e st;
  logic    at_a, at_b;

  assign at_a = (wr_addr == ADR_A);
  assign at_b = (wr_addr == ADR_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= D_IDLE;
      op_valid <= 1'b0;
      op_kind  <= OP_PROG;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= 1'b0;
      if (busy) begin
        st <= D_IDLE;
      end else if (wr_valid) begin
        st <= D_IDLE;
        unique case (st)
          D_IDLE: if (at_a && wr_data == K_UNL1) st <= D_U1;
          D_U1:   if (at_b && wr_data == K_UNL2) st <= D_U2;
          D_U2: begin
            if (at_a && wr_data == K_PROG)     st <= D_PGM;
            else if (at_a && wr_data == K_ERS) st <= D_E1;
          end
          D_PGM: begin
            op_valid <= 1'b1;
            op_kind  <= OP_PROG;
            op_addr  <= wr_addr;
            op_data  <= wr_data;
          end
          D_E1: if (at_a && wr_data == K_UNL1) st <= D_E2;
          D_E2: if (at_b && wr_data == K_UNL2) st <= D_E3;
          D_E3: begin
            op_addr <= wr_addr;
            op_data <= wr_data;
            if (at_a && wr_data == K_CHIP) begin
              op_valid <= 1'b1;
              op_kind  <= OP_CHIP;
            end else if (wr_data == K_SECT) begin
              op_valid <= 1'b1;
              op_kind  <= OP_SECT;
            end else if (wr_data == K_BLK) begin
              op_valid <= 1'b1;
              op_kind  <= OP_BLK;
            end
          end
          default: st <= D_IDLE;
        endcase
      end
    end
  end

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> !op_valid);
endmodule

// File: rtl/pflash_array.sv
// Byte array: port A read/write for the engine, port B read-only for the host.
module pflash_array #(
  parameter int AW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/pflash_exec.sv
// Runs accepted operations: program read-modify-write, erase walk, busy timer.
module pflash_exec
  import pflash_pkg::*;
#(
  parameter int AW           = 9,
  parameter int DEPTH        = 512,
  parameter int SECTOR_BYTES = 16,
  parameter int BLOCK_BYTES  = 256,
  parameter int T_PROG       = 16,
  parameter int T_SECT       = 100,
  parameter int T_BLK        = 300,
  parameter int T_CHIP       = 520
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  op_e           op_kind,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  output logic          busy,
  output logic          poll7,
  output logic [AW-1:0] a_addr,
  output logic          a_we,
  output logic [7:0]    a_wdata,
  input  logic [7:0]    a_rdata
);
  localparam int TW = $clog2(T_PROG + T_SECT + T_BLK + T_CHIP + 1);
  localparam logic [AW-1:0] SMASK = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] BMASK = AW'(BLOCK_BYTES - 1);
  localparam logic [AW-1:0] TOP   = AW'(DEPTH - 1);

  typedef enum logic [2:0] {E_IDLE, E_RD, E_WR, E_ERASE, E_WAIT} estate_e;

  estate_e       st;
  logic [AW-1:0] ptr, hi;
  logic [7:0]    pd;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= E_IDLE;
      ptr   <= '0;
      hi    <= '0;
      pd    <= '0;
      tmr   <= '0;
      poll7 <= 1'b0;
    end else begin
      if (tmr != '0) tmr <= tmr - 1'b1;
      unique case (st)
        E_IDLE: if (op_valid) begin
          pd    <= op_data;
          poll7 <= (op_kind == OP_PROG) ? ~op_data[7] : 1'b0;
          unique case (op_kind)
            OP_PROG: begin
              ptr <= op_addr;
              tmr <= TW'(T_PROG);
              st  <= E_RD;
            end
            OP_SECT: begin
              ptr <= op_addr & ~SMASK;
              hi  <= op_addr | SMASK;
              tmr <= TW'(T_SECT);
              st  <= E_ERASE;
            end
            OP_BLK: begin
              ptr <= op_addr & ~BMASK;
              hi  <= op_addr | BMASK;
              tmr <= TW'(T_BLK);
              st  <= E_ERASE;
            end
            default: begin
              ptr <= '0;
              hi  <= TOP;
              tmr <= TW'(T_CHIP);
              st  <= E_ERASE;
            end
          endcase
        end
        E_RD:    st <= E_WR;
        E_WR:    st <= E_WAIT;
        E_ERASE: begin
          if (ptr == hi) st <= E_WAIT;
          else           ptr <= ptr + 1'b1;
        end
        E_WAIT:  if (tmr == '0) st <= E_IDLE;
        default: st <= E_IDLE;
      endcase
    end
  end

  assign busy    = (st != E_IDLE);
  assign a_addr  = ptr;
  assign a_we    = (st == E_WR) || (st == E_ERASE);
  assign a_wdata = (st == E_WR) ? (a_rdata & pd) : 8'hFF;

  // R4
  walk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st == E_ERASE) |=> (st == E_WAIT) || (st == E_ERASE && ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/pflash_engine.sv
module pflash_engine
  import pflash_pkg::*;
#(
  parameter int         SECTOR_BYTES  = 16,
  parameter int         BLOCK_SECTORS = 16,
  parameter int         BLOCKS        = 2,
  parameter int         MIN_PULSE     = 3,
  parameter int         T_PROG        = 16,
  parameter int         T_SECT        = 100,
  parameter int         T_BLK         = 300,
  parameter int         T_CHIP        = 520,
  parameter int         UNLOCK_A      = 'h055,
  parameter int         UNLOCK_B      = 'h0AA,
  parameter logic [7:0] K_UNL1        = 8'hAA,
  parameter logic [7:0] K_UNL2        = 8'h55,
  parameter logic [7:0] K_PROG        = 8'hA0,
  parameter logic [7:0] K_ERS         = 8'h80,
  parameter logic [7:0] K_CHIP        = 8'h10,
  parameter logic [7:0] K_SECT        = 8'h30,
  parameter logic [7:0] K_BLK         = 8'h50,
  localparam int        BLOCK_BYTES   = SECTOR_BYTES * BLOCK_SECTORS,
  localparam int        DEPTH         = BLOCK_BYTES * BLOCKS,
  localparam int        AW            = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          supply_low,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout
);
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          op_valid;
  op_e           op_kind;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data;
  logic          busy, poll7;
  logic [AW-1:0] a_addr;
  logic          a_we;
  logic [7:0]    a_wdata, a_rdata, b_rdata;

  pflash_wfilt #(.AW(AW), .MIN_PULSE(MIN_PULSE)) u_wfilt (
    .clk, .rst, .ce_n, .oe_n, .we_n, .supply_low, .addr, .din,
    .wr_valid, .wr_addr, .wr_data
  );

  pflash_cmdseq #(
    .AW(AW), .UNLOCK_A(UNLOCK_A), .UNLOCK_B(UNLOCK_B),
    .K_UNL1(K_UNL1), .K_UNL2(K_UNL2), .K_PROG(K_PROG), .K_ERS(K_ERS),
    .K_CHIP(K_CHIP), .K_SECT(K_SECT), .K_BLK(K_BLK)
  ) u_cmdseq (
    .clk, .rst, .busy, .wr_valid, .wr_addr, .wr_data,
    .op_valid, .op_kind, .op_addr, .op_data
  );

  pflash_exec #(
    .AW(AW), .DEPTH(DEPTH), .SECTOR_BYTES(SECTOR_BYTES), .BLOCK_BYTES(BLOCK_BYTES),
    .T_PROG(T_PROG), .T_SECT(T_SECT), .T_BLK(T_BLK), .T_CHIP(T_CHIP)
  ) u_exec (
    .clk, .rst, .op_valid, .op_kind, .op_addr, .op_data,
    .busy, .poll7, .a_addr, .a_we, .a_wdata, .a_rdata
  );

  pflash_array #(.AW(AW), .DEPTH(DEPTH)) u_array (
    .clk, .a_addr, .a_we, .a_wdata, .a_rdata, .b_addr(addr), .b_rdata
  );

  // status read path: toggle flips at the start of each read while busy
  logic       rd_act, rd_prev, rd_start, tog, tog_nx, sel_stat;
  logic [7:0] stat_q;

  assign rd_act   = ~ce_n & ~oe_n;
  assign rd_start = rd_act & ~rd_prev;
  assign tog_nx   = tog ^ (busy & rd_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev  <= 1'b0;
      tog      <= 1'b0;
      stat_q   <= '0;
      sel_stat <= 1'b0;
    end else begin
      rd_prev  <= rd_act;
      tog      <= tog_nx;
      stat_q   <= {poll7, tog_nx, 6'b0};
      sel_stat <= busy;
    end
  end

  assign dout = sel_stat ? stat_q : b_rdata;

  // R3
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(tog));
endmodule

// File: tb/pflash_engine_tb.sv
module pflash_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_engine #(
    .SECTOR_BYTES(16), .BLOCK_SECTORS(16), .BLOCKS(2), .MIN_PULSE(3),
    .T_PROG(16), .T_SECT(100), .T_BLK(300), .T_CHIP(520)
  ) dut_i (
    .clk, .rst, .ce_n, .oe_n, .we_n, .supply_low, .addr, .din, .dout
  );

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [7:0] d, input int cyc, input bit oe_low);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
    repeat (cyc) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    v = dout;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic poll(output bit ok);
    logic [7:0] p, q;
    ok = 1'b0;
    rd(9'h000, p);
    for (int k = 0; k < 2000; k++) begin
      rd(9'h000, q);
      if (q == p) begin ok = 1'b1; break; end
      p = q;
    end
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    bit ok;
    bw(9'h055, 8'hAA, 4, 0); bw(9'h0AA, 8'h55, 4, 0);
    bw(9'h055, 8'hA0, 4, 0); bw(a, d, 4, 0);
    poll(ok);
  endtask

  task automatic erase_pre();
    bw(9'h055, 8'hAA, 4, 0); bw(9'h0AA, 8'h55, 4, 0); bw(9'h055, 8'h80, 4, 0);
    bw(9'h055, 8'hAA, 4, 0); bw(9'h0AA, 8'h55, 4, 0);
  endtask

  // vector: op[31:29] addr[28:20] data[19:12] expect[11:4] req[3:0]
  // op 0 write, 1 read+check, 2 short write, 3 write with OE# low, 4 wait idle
  localparam int NV = 29;
  localparam logic [31:0] VEC [NV] = '{
    {3'd0, 9'h055, 8'hAA, 8'h00, 4'd2},
    {3'd0, 9'h0AA, 8'h55, 8'h00, 4'd2},
    {3'd0, 9'h055, 8'hA0, 8'h00, 4'd2},
    {3'd0, 9'h010, 8'h5A, 8'h00, 4'd2},
    {3'd4, 9'h000, 8'h00, 8'h00, 4'd2},
    {3'd1, 9'h010, 8'h00, 8'h5A, 4'd2},   // R2 first program
    {3'd0, 9'h055, 8'hAA, 8'h00, 4'd2},
    {3'd0, 9'h0AA, 8'h55, 8'h00, 4'd2},
    {3'd0, 9'h055, 8'hA0, 8'h00, 4'd2},
    {3'd0, 9'h010, 8'h0F, 8'h00, 4'd2},
    {3'd4, 9'h000, 8'h00, 8'h00, 4'd2},
    {3'd1, 9'h010, 8'h00, 8'h0A, 4'd2},   // R2 AND with old byte
    {3'd1, 9'h011, 8'h00, 8'hFF, 4'd1},   // R1 untouched neighbour
    {3'd0, 9'h055, 8'hAA, 8'h00, 4'd8},
    {3'd0, 9'h055, 8'h55, 8'h00, 4'd8},   // R8 wrong address
    {3'd0, 9'h055, 8'hA0, 8'h00, 4'd8},
    {3'd0, 9'h020, 8'h00, 8'h00, 4'd8},
    {3'd4, 9'h000, 8'h00, 8'h00, 4'd8},
    {3'd1, 9'h020, 8'h00, 8'hFF, 4'd8},   // R8
    {3'd2, 9'h055, 8'hAA, 8'h00, 4'd10},  // R10 short pulse
    {3'd0, 9'h0AA, 8'h55, 8'h00, 4'd10},
    {3'd0, 9'h055, 8'hA0, 8'h00, 4'd10},
    {3'd0, 9'h030, 8'h00, 8'h00, 4'd10},
    {3'd1, 9'h030, 8'h00, 8'hFF, 4'd10},  // R10
    {3'd3, 9'h055, 8'hAA, 8'h00, 4'd9},   // R9 OE# low
    {3'd0, 9'h0AA, 8'h55, 8'h00, 4'd9},
    {3'd0, 9'h055, 8'hA0, 8'h00, 4'd9},
    {3'd0, 9'h040, 8'h00, 8'h00, 4'd9},
    {3'd1, 9'h040, 8'h00, 8'hFF, 4'd9}    // R9
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=00 expected=01");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v, w;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R1 reset state reads erased array
    rd(9'h000, v);
    check(v == 8'hFF, "R1", v, 8'hFF);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][31:29];
      case (op)
        3'd0: bw(VEC[i][28:20], VEC[i][19:12], 4, 0);
        3'd2: bw(VEC[i][28:20], VEC[i][19:12], 2, 0);
        3'd3: bw(VEC[i][28:20], VEC[i][19:12], 4, 1);
        3'd4: poll(ok);
        default: begin
          rd(VEC[i][28:20], v);
          check(v == VEC[i][11:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i), v, VEC[i][11:4]);
        end
      endcase
    end

    // R3 program status: DQ7 complement, DQ6 toggles, then true data
    bw(9'h055, 8'hAA, 4, 0); bw(9'h0AA, 8'h55, 4, 0);
    bw(9'h055, 8'hA0, 4, 0); bw(9'h050, 8'h33, 4, 0);
    rd(9'h050, v);
    rd(9'h050, w);
    check(v[7] == 1'b1, "R3 poll bit", v, 8'h80);
    check(v[6] != w[6], "R3 toggle", w, {v[7], ~v[6], 6'b0});
    poll(ok);
    check(ok, "R3 completion", {7'b0, ok}, 8'h01);
    rd(9'h050, v);
    check(v == 8'h33, "R3 data", v, 8'h33);

    // R4 sector erase
    prog(9'h105, 8'h00);
    prog(9'h110, 8'h00);
    erase_pre();
    bw(9'h108, 8'h30, 4, 0);
    rd(9'h000, v);
    check(v[7] == 1'b0, "R4 poll bit", v, 8'h00);
    poll(ok);
    rd(9'h105, v);
    check(v == 8'hFF, "R4 in sector", v, 8'hFF);
    rd(9'h110, v);
    check(v == 8'h00, "R4 next sector", v, 8'h00);
    rd(9'h010, v);
    check(v == 8'h0A, "R4 other block", v, 8'h0A);

    // R5 block erase of upper block
    prog(9'h1F0, 8'h00);
    erase_pre();
    bw(9'h1C0, 8'h50, 4, 0);
    poll(ok);
    rd(9'h110, v);
    check(v == 8'hFF, "R5 in block", v, 8'hFF);
    rd(9'h1F0, v);
    check(v == 8'hFF, "R5 block end", v, 8'hFF);
    rd(9'h010, v);
    check(v == 8'h0A, "R5 other block", v, 8'h0A);

    // R7 program sequence issued during a sector erase is ignored
    erase_pre();
    bw(9'h003, 8'h30, 4, 0);
    bw(9'h055, 8'hAA, 4, 0); bw(9'h0AA, 8'h55, 4, 0);
    bw(9'h055, 8'hA0, 4, 0); bw(9'h1F0, 8'h00, 4, 0);
    poll(ok);
    rd(9'h1F0, v);
    check(v == 8'hFF, "R7", v, 8'hFF);

    // R11 supply low blocks a full program sequence
    supply_low = 1'b1;
    prog(9'h060, 8'h00);
    supply_low = 1'b0;
    rd(9'h060, v);
    check(v == 8'hFF, "R11", v, 8'hFF);

    // R6 chip erase only after all six cycles
    prog(9'h080, 8'h00);
    erase_pre();
    rd(9'h080, v);
    check(v == 8'h00, "R6 five cycles", v, 8'h00);
    bw(9'h055, 8'h10, 4, 0);
    poll(ok);
    rd(9'h080, v);
    check(v == 8'hFF, "R6 erased", v, 8'hFF);
    rd(9'h010, v);
    check(v == 8'hFF, "R6 whole array", v, 8'hFF);
    rd(9'h050, v);
    check(v == 8'hFF, "R6 whole array", v, 8'hFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule